// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets software reach the management registers of an external Ethernet PHY through two memory-mapped words. One word is a combined command/status word. Software first checks that its busy flag is clear. It then writes the PHY address, the register number, a direction bit and, for writes, 16 data bits. The controller runs one clause-22 management frame on the MDC/MDIO pair. For a read, software polls the read-valid flag and then takes the 16-bit result from the low half of the same word. A write raises no completion flag, and software only waits for busy to clear before it issues the next command.

The second word holds the port's own 5-bit PHY address. Only its low 5 bits are stored, so a read-modify-write of that field touches nothing else. MDC is made by dividing the system clock by `2*DIV_HALF`, and it toggles only while a frame is in flight. MDIO changes on the falling edge of MDC. Read data is sampled on the rising edge. During the turnaround and data phase of a read, the driver lets go of the line.

The register port has no back-pressure: an access is taken in the cycle it is presented, and read data is a combinational function of `csr_sel`. No streaming data path exists, so all pins are plain control, status or data signals.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The command word (`csr_sel`=0) reads back as: data in bits 15:0, PHY address in bits 20:16, register number in bits 25:21, direction in bit 26 (1 = read, 0 = write), read-valid in bit 27, busy in bit 28, and zero in bits 31:29.
- R2: A write frame, seen as 64 MDIO bits sampled on rising MDC edges, is 32 ones, `01`, `01`, 5 PHY-address bits, 5 register bits, `10`, then the 16 data bits, each field sent MSB first. The driver is enabled for all 64 bits.
- R3: A read frame sends 32 ones, `01`, `10`, the PHY address and the register number (46 bits, all driven). The driver is released for the remaining 18 bits, which are turnaround plus data.
- R4: When a read completes, bits 15:0 hold the 16 bits sampled on the last 16 rising MDC edges (first sample is the MSB), and read-valid (bit 27) is 1.
- R5: Busy (bit 28) reads 1 in the cycle after a command is accepted. It reads 0 again exactly `128*DIV_HALF` clock edges after the accepting edge.
- R6: A command-word write while busy is 1 is ignored: the frame in flight and the stored fields do not change.
- R7: An accepted command clears read-valid in the same edge that sets busy.
- R8: The PHY-address word (`csr_sel`=1) stores `csr_wdata[4:0]` and reads back with bits 31:5 zero. Writing it leaves the command word unchanged.
- R9: MDC is low and `mdio_oe` is 0 while idle. A frame has exactly 64 rising MDC edges. `mdio_o` changes only on a falling MDC edge while a frame runs.
- R10: After reset both words read 0, MDC is low and the driver is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | Word select: 0 = command/status, 1 = own PHY address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Combinational read data for the selected word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO driver enable |

## Verification
Busy is due on the first sampling point after the accepting edge. It falls after exactly `128*DIV_HALF` further edges, so the bench counts clock edges from acceptance to the first negative-edge sample that shows busy clear, and compares that count. The 64-bit frame and the driver-enable pattern are captured by a PHY model on each rising MDC edge. The model supplies read data on falling MDC edges, so the design's rising-edge sample never races it. The read result, read-valid and the fields that were rejected while busy are checked once busy has cleared. All register reads are taken one time unit after a falling clock edge, well away from the active edge.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int CSR_W     = 32;
  localparam int PHY_LSB   = 16;
  localparam int REG_LSB   = PHY_LSB + ADDR_W;
  localparam int OP_BIT    = REG_LSB + ADDR_W;
  localparam int RVALID_BIT = OP_BIT + 1;
  localparam int BUSY_BIT  = OP_BIT + 2;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;
  localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] regad;
    logic [ADDR_W-1:0] phy;
    logic [DATA_W-1:0] data;
  } mgmt_cmd_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(mgmt_cmd_t c);
    logic [1:0] opc;
    logic [1:0] ta;
    logic [DATA_W-1:0] payload;
    opc     = c.rd ? 2'b10 : 2'b01;
    ta      = c.rd ? 2'b11 : 2'b10;
    payload = c.rd ? '0 : c.data;
    return {{PRE_LEN{1'b1}}, 2'b01, opc, c.phy, c.regad, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  logic tick;

  generate
    if (DIV_HALF <= 1) begin : g_nocnt
      assign tick = run;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV_HALF);
      logic [CW-1:0] cnt;
      assign tick = run && (cnt == CW'(DIV_HALF - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || !run) mdc <= 1'b0;
    else if (tick)      mdc <= ~mdc;
  end

  assign rise_stb = tick && !mdc;
  assign fall_stb = tick && mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mgmt_cmd_t         cmd_in,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  bit_idx
);
  logic [FRAME_LEN-1:0] tx_sr;
  logic [DATA_W-1:0]    rx_sr;
  logic                 active;
  logic                 is_rd;
  logic                 last;
  logic                 released;

  assign last     = (bit_idx == IDX_W'(FRAME_LEN - 1));
  assign done     = active && fall_stb && last;
  assign released = is_rd && (bit_idx >= IDX_W'(TA_POS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      bit_idx <= '0;
      active  <= 1'b0;
      is_rd   <= 1'b0;
    end else if (start) begin
      tx_sr   <= build_frame(cmd_in);
      bit_idx <= '0;
      active  <= 1'b1;
      is_rd   <= cmd_in.rd;
    end else if (active && fall_stb) begin
      tx_sr <= tx_sr << 1;
      if (last) active  <= 1'b0;
      else      bit_idx <= bit_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rx_sr <= '0;
    else if (active && rise_stb && is_rd && bit_idx >= IDX_W'(DATA_POS))
      rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
  end

  assign rd_data = rx_sr;
  assign mdio_o  = active ? tx_sr[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = active && !released;
endmodule

// File: rtl/mdio_csr_file.sv
module mdio_csr_file
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic              csr_sel,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic              start,
  output mgmt_cmd_t         cmd,
  output logic              busy,
  output logic              rvalid,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] own_phy;
  mgmt_cmd_t         decoded;
  logic              unused_hi;

  assign unused_hi = ^csr_wdata[CSR_W-1:OP_BIT+1];
  assign start     = csr_we && !csr_sel && !busy;

  always_comb begin
    decoded.rd    = csr_wdata[OP_BIT];
    decoded.regad = csr_wdata[REG_LSB +: ADDR_W];
    decoded.phy   = csr_wdata[PHY_LSB +: ADDR_W];
    decoded.data  = csr_wdata[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd    <= '0;
      busy   <= 1'b0;
      rvalid <= 1'b0;
    end else if (start) begin
      cmd    <= decoded;
      busy   <= 1'b1;
      rvalid <= 1'b0;
    end else if (done) begin
      busy <= 1'b0;
      if (cmd.rd) begin
        rvalid   <= 1'b1;
        cmd.data <= rd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                own_phy <= '0;
    else if (csr_we && csr_sel) own_phy <= csr_wdata[ADDR_W-1:0];
  end

  always_comb begin
    csr_rdata = '0;
    if (!csr_sel) begin
      csr_rdata[DATA_W-1:0]          = cmd.data;
      csr_rdata[PHY_LSB +: ADDR_W]   = cmd.phy;
      csr_rdata[REG_LSB +: ADDR_W]   = cmd.regad;
      csr_rdata[OP_BIT]              = cmd.rd;
      csr_rdata[RVALID_BIT]          = rvalid;
      csr_rdata[BUSY_BIT]            = busy;
    end else begin
      csr_rdata[ADDR_W-1:0] = own_phy;
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic        csr_sel,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  mgmt_cmd_t         cmd;
  logic              start;
  logic              busy;
  logic              rvalid;
  logic              done;
  logic              rise_stb;
  logic              fall_stb;
  logic [DATA_W-1:0] rd_data;
  logic [IDX_W-1:0]  bit_idx;

  mdio_csr_file u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_we   (csr_we),
    .csr_sel  (csr_sel),
    .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata),
    .start    (start),
    .cmd      (cmd),
    .busy     (busy),
    .rvalid   (rvalid),
    .done     (done),
    .rd_data  (rd_data)
  );

  mdio_mdc_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .mdc     (mdc),
    .rise_stb(rise_stb),
    .fall_stb(fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cmd_in  (cmd_next(csr_wdata)),
    .rise_stb(rise_stb),
    .fall_stb(fall_stb),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (done),
    .rd_data (rd_data),
    .bit_idx (bit_idx)
  );

  function automatic mgmt_cmd_t cmd_next(logic [31:0] w);
    mgmt_cmd_t c;
    c.rd    = w[OP_BIT];
    c.regad = w[REG_LSB +: ADDR_W];
    c.phy   = w[PHY_LSB +: ADDR_W];
    c.data  = w[DATA_W-1:0];
    return c;
  endfunction
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
  import mdio_mgmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic              csr_sel,
  input logic              busy,
  input logic              rvalid,
  input logic              cmd_rd,
  input logic [ADDR_W-1:0] cmd_phy,
  input logic [ADDR_W-1:0] cmd_reg,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic [IDX_W-1:0]  bit_idx
);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_drive_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  p_write_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_rd) |-> mdio_oe);

  p_turnaround_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_rd && bit_idx >= IDX_W'(TA_POS)) |-> !mdio_oe);

  p_read_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cmd_rd) |-> rvalid);

  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && csr_we && !csr_sel) |=> $stable({cmd_rd, cmd_phy, cmd_reg}));

  p_rvalid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && csr_we && !csr_sel) |=> (busy && !rvalid));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .csr_we (csr_we),
  .csr_sel(csr_sel),
  .busy   (busy),
  .rvalid (rvalid),
  .cmd_rd (cmd.rd),
  .cmd_phy(cmd.phy),
  .cmd_reg(cmd.regad),
  .mdc    (mdc),
  .mdio_o (mdio_o),
  .mdio_oe(mdio_oe),
  .bit_idx(bit_idx)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
  localparam int H = 2;

  logic        clk;
  logic        rst_n;
  logic        csr_we;
  logic        csr_sel;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        mdc;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] cap;
  logic [63:0] oecap;
  int          rises;
  logic [15:0] phy_rd;
  logic [31:0] last_exp;

  mdio_mgmt_ctrl #(.DIV_HALF(H)) dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  initial begin
    clk = 0;
    forever #5 clk = ~clk;
  end

  // PHY model: captures on rising MDC, supplies read data on falling MDC
  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_o};
    oecap = {oecap[62:0], mdio_oe};
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises <= 63) mdio_i = phy_rd[63 - rises];
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd_word(bit rd, logic [4:0] phy, logic [4:0] rg,
                                           logic [15:0] d);
    return {5'b0, rd, rg, phy, d};
  endfunction

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] phy, logic [4:0] rg,
                                            logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
  endfunction

  task automatic run_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, input logic [15:0] resp,
                         input int poke_at);
    logic [31:0] word;
    logic [63:0] ef;
    logic [31:0] exp_rb;
    int cycles;
    string ftag;
    word   = cmd_word(rd, phy, rg, d);
    ef     = exp_frame(rd, phy, rg, d);
    rises  = 0;
    cap    = '0;
    oecap  = '0;
    mdio_i = 1'b1;
    phy_rd = resp;
    csr_sel   = 1'b0;
    csr_wdata = word;
    csr_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    csr_we = 1'b0;
    #1;
    check(csr_rdata[28] == 1'b1, "R5 busy after accept", csr_rdata[28], 1);
    check(csr_rdata[27] == 1'b0, "R7 read-valid cleared", csr_rdata[27], 0);
    cycles = 0;
    while (csr_rdata[28] && cycles < 100000) begin
      if (cycles == poke_at) begin
        csr_wdata = word ^ 32'h07FF_FFFF;
        csr_we    = 1'b1;
      end
      @(posedge clk);
      cycles++;
      @(negedge clk);
      csr_we = 1'b0;
      #1;
    end
    check(cycles == 128 * H, "R5 busy duration", cycles, 128 * H);
    check(rises == 64, "R9 rising MDC count", rises, 64);
    check(!mdc && !mdio_oe, "R9 idle quiet", {mdc, mdio_oe}, 0);
    ftag = (poke_at >= 0) ? "R6 frame kept" : (rd ? "R3 read frame" : "R2 write frame");
    if (rd) begin
      check(cap[63:18] == ef[63:18], ftag, cap, ef);
      check(oecap == {{46{1'b1}}, 18'b0}, "R3 driver release", oecap,
            {{46{1'b1}}, 18'b0});
    end else begin
      check(cap == ef, ftag, cap, ef);
      check(oecap == {64{1'b1}}, "R2 driver enable", oecap, {64{1'b1}});
    end
    exp_rb = {3'b000, 1'b0, rd, rd, rg, phy, (rd ? resp : d)};
    check(csr_rdata == exp_rb,
          (poke_at >= 0) ? "R6 fields kept" : (rd ? "R4 read result" : "R1 readback"),
          csr_rdata, exp_rb);
    last_exp = exp_rb;
  endtask

  initial begin
    rst_n = 0; csr_we = 0; csr_sel = 0; csr_wdata = '0; mdio_i = 1'b1;
    rises = 0; cap = '0; oecap = '0; phy_rd = '0; last_exp = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R10 reset state
    check(csr_rdata == 32'h0, "R10 command word", csr_rdata, 0);
    check(!mdc, "R10 mdc low", mdc, 0);
    check(!mdio_oe, "R10 driver released", mdio_oe, 0);
    csr_sel = 1'b1;
    #1;
    check(csr_rdata == 32'h0, "R10 phy address word", csr_rdata, 0);

    // directed corners
    run_cmd(1'b0, 5'h1F, 5'h00, 16'hA5C3, 16'h0000, -1);
    run_cmd(1'b1, 5'h00, 5'h1F, 16'h0000, 16'h8001, -1);
    run_cmd(1'b0, 5'h0A, 5'h15, 16'hFFFF, 16'h0000, 40);
    run_cmd(1'b1, 5'h15, 5'h0A, 16'h1234, 16'h7FFE, 100);
    run_cmd(1'b1, 5'h03, 5'h01, 16'h0000, 16'hC3A5, -1);
    run_cmd(1'b0, 5'h03, 5'h04, 16'h0001, 16'h0000, -1); // R7 after a read

    // R8 own PHY address word
    @(negedge clk);
    csr_sel = 1'b1; csr_wdata = 32'hFFFF_FFE5; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
    #1;
    check(csr_rdata == 32'h0000_0005, "R8 low bits only", csr_rdata, 32'h5);
    @(negedge clk);
    csr_wdata = 32'hDEAD_BEFF; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
    #1;
    check(csr_rdata == 32'h0000_001F, "R8 overwrite", csr_rdata, 32'h1F);
    csr_sel = 1'b0;
    #1;
    check(csr_rdata == last_exp, "R8 command word untouched", csr_rdata, last_exp);

    // constrained random
    for (int i = 0; i < 8; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_cmd(r[31], r[4:0], r[9:5], r[25:10], $urandom, ((i % 3) == 0) ? 20 + i : -1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule